// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block turns a parallel word into a serial bit stream. A holding register first captures the parallel pins when a capture strobe rises. A shift register behind it is then either filled from the holding register or advanced one place per shift strobe. Serial data enters at stage 0, and the last stage drives the serial line. Both strobes may come from another clock domain. Each is synchronised and edge-detected inside the single system clock, so one rising edge of a strobe acts exactly once.

The fill control `load_n` is an active-low level. It is sampled on every cycle, and while it is low it takes priority over any shift request. The serial output is built from a data bit and a drive enable. With the enable off, the line floats, so several shifters can share one wired serial line. A typical use is to capture a status word, pulse `load_n` once, and then clock the word out with the highest bit first.

Top module: `piso_latched_shifter`

## Requirements
- R1: After a synchronous active-low reset, both the holding register and the shift register hold all zeros.
- R2: A rising edge on `cap_strobe` copies `par_in` into the holding register. Bit 0 of `par_in` is the first stage and bit WIDTH-1 is the last stage.
- R3: While `load_n` is low, the shift register is refilled from the holding register on every cycle, and a shift strobe edge in that time has no effect.
- R4: While `load_n` is high, a rising edge on `shift_strobe` moves every stage one place toward bit WIDTH-1 and loads `ser_in` into bit 0. With no edge, the shift register holds its value.
- R5: When both strobes rise together with `load_n` high, the shift register shifts its own previous contents, and the holding register takes the new `par_in` in the same cycle.
- R6: When `cap_strobe` rises while `load_n` is low, the shift register receives the new `par_in` in the same cycle that the holding register captures it.
- R7: With `oe_n` low, `ser_oe` is 1 and `ser_out` shows bit WIDTH-1 of the shift register. With `oe_n` high, `ser_oe` is 0 and `ser_out` is high-impedance, while the registers keep working.
- R8: A strobe held high for many cycles acts only once. It acts again only after it has gone low and risen again.
- R9: Without a `cap_strobe` edge, the holding register keeps its value through shifts and fills.
- R10: A strobe rise becomes effective in the register on the third rising clock edge after the strobe is first seen high, given the default two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_in | input | WIDTH | Parallel word to capture |
| cap_strobe | input | 1 | Capture strobe, acts on its rising edge (asynchronous) |
| shift_strobe | input | 1 | Shift strobe, acts on its rising edge (asynchronous) |
| load_n | input | 1 | Active-low fill of the shift register from the holding register |
| ser_in | input | 1 | Serial data into stage 0 |
| oe_n | input | 1 | Active-low serial output enable |
| ser_out | output | 1 | Serial output, last stage, high-impedance when disabled |
| ser_oe | output | 1 | Drive enable of the serial output |

## Verification
A bad bit in the shift register shows at `ser_out` as soon as that bit reaches the last stage. That takes at most WIDTH-1 shift edges, so shifting a whole word out after each fill exposes every stage. A fault in the holding register stays hidden until the next fill, so the bench always fills and drains the word after each capture. For the same-cycle capture while filling, the bench samples at the single cycle where the old and new words differ. A missed or repeated strobe edge moves the whole stream by one bit, and the very next bit shows the error.

// File: rtl/piso_pkg.sv
// piso_pkg: types and decode shared by the latched shifter.
// Assumes the strobes have already been turned into one-cycle pulses.
package piso_pkg;

    // What the shift register does in a given cycle.
    typedef enum logic [1:0] {
        ACT_HOLD       = 2'd0,
        ACT_FILL_STORE = 2'd1,
        ACT_FILL_PINS  = 2'd2,
        ACT_SHIFT      = 2'd3
    } shift_act_t;

    // The fill level wins over the shift. A capture during a fill passes the pins through.
    function automatic shift_act_t decode_act(input logic load_n,
                                              input logic cap_pulse,
                                              input logic shift_pulse);
        shift_act_t act;
        if (!load_n) begin
            act = cap_pulse ? ACT_FILL_PINS : ACT_FILL_STORE;
        end else if (shift_pulse) begin
            act = ACT_SHIFT;
        end else begin
            act = ACT_HOLD;
        end
        return act;
    endfunction

endpackage

// File: rtl/piso_edge_sync.sv
// piso_edge_sync: brings an asynchronous strobe into the clock domain and
// gives a one-cycle pulse per rising edge. Assumes STAGES >= 2.
// Latency: the pulse is high in the cycle after the STAGES-th clock edge
// that sees the strobe high.
module piso_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_raw,
    output logic rise_pulse
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // First flop samples the raw strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= strobe_raw;
        end
    end

    genvar gi;
    generate
        for (gi = 1; gi < CHAIN; gi++) begin : g_stage
            // Each further flop delays the previous stage by one clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[gi] <= 1'b0;
                end else begin
                    chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    // Pulse when the synchronised level is high and the previous level was low.
    always_comb begin
        rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
    end

endmodule

// File: rtl/piso_capture_reg.sv
// piso_capture_reg: holding register for the parallel word.
// Takes par_in only on a capture pulse and keeps its value otherwise.
module piso_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pulse,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] store_q
);
    // Capture the parallel word on the pulse, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (cap_pulse) begin
            store_q <= par_in;
        end
    end

endmodule

// File: rtl/piso_shift_core.sv
// piso_shift_core: the shift register. It fills from the holding register
// or from the pins, shifts toward the top bit, or holds.
// Assumes WIDTH >= 2. Bit WIDTH-1 is the last stage.
module piso_shift_core
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  shift_act_t       act,
    input  logic [WIDTH-1:0] store_q,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] shift_q
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] shift_d;

    // Next-state selection according to the decoded action.
    always_comb begin
        unique case (act)
            ACT_FILL_STORE: shift_d = store_q;
            ACT_FILL_PINS:  shift_d = par_in;
            ACT_SHIFT:      shift_d = {shift_q[LAST-1:0], ser_in};
            default:        shift_d = shift_q;
        endcase
    end

    // State update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= shift_d;
        end
    end

endmodule

// File: rtl/piso_latched_shifter.sv
// piso_latched_shifter: top level. Holding register, shift register and a
// three-state serial output. Both strobes are edge-detected, load_n is used
// as a level. Assumes a single clock and inputs held for at least one cycle.
module piso_latched_shifter
    import piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             cap_strobe,
    input  logic             shift_strobe,
    input  logic             load_n,
    input  logic             ser_in,
    input  logic             oe_n,
    output logic             ser_out,
    output logic             ser_oe
);
    localparam int LAST    = WIDTH - 1;
    localparam int NSTROBE = 2;

    logic [NSTROBE-1:0] strobe_raw;
    logic [NSTROBE-1:0] strobe_pulse;
    logic               cap_pulse;
    logic               shift_pulse;
    logic [WIDTH-1:0]   store_q;
    logic [WIDTH-1:0]   shift_q;
    shift_act_t         act;

    // Group the strobes so that one synchroniser is built per strobe.
    always_comb begin
        strobe_raw = {shift_strobe, cap_strobe};
    end

    genvar si;
    generate
        for (si = 0; si < NSTROBE; si++) begin : g_sync
            piso_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .strobe_raw (strobe_raw[si]),
                .rise_pulse (strobe_pulse[si])
            );
        end
    endgenerate

    // Split the pulse vector back into named pulses.
    always_comb begin
        cap_pulse   = strobe_pulse[0];
        shift_pulse = strobe_pulse[1];
    end

    piso_capture_reg #(.WIDTH(WIDTH)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pulse (cap_pulse),
        .par_in    (par_in),
        .store_q   (store_q)
    );

    // Decode the action of the shift register for this cycle.
    always_comb begin
        act = decode_act(load_n, cap_pulse, shift_pulse);
    end

    piso_shift_core #(.WIDTH(WIDTH)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .store_q (store_q),
        .par_in  (par_in),
        .ser_in  (ser_in),
        .shift_q (shift_q)
    );

    // Drive enable of the serial line.
    always_comb begin
        ser_oe = ~oe_n;
    end

    // Three-state serial output.
    assign ser_out = ser_oe ? shift_q[LAST] : 1'bz;

endmodule

// File: rtl/piso_latched_shifter_chk.sv
// piso_latched_shifter_chk: checker bound to the top. It checks how the
// registers move from one cycle to the next against the pulses and the level inputs.
module piso_latched_shifter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] par_in,
    input logic             load_n,
    input logic             ser_in,
    input logic             cap_pulse,
    input logic             shift_pulse,
    input logic [WIDTH-1:0] store_q,
    input logic [WIDTH-1:0] shift_q
);
    localparam int LAST = WIDTH - 1;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (store_q == '0 && shift_q == '0)); // R1

    AST_CAPTURE_TAKES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> store_q == $past(par_in)); // R2

    AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(store_q)); // R9

    AST_FILL_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !cap_pulse) |=> shift_q == $past(store_q)); // R3

    AST_FILL_PASS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && cap_pulse) |=> shift_q == $past(par_in)); // R6

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && shift_pulse) |=>
            shift_q == {$past(shift_q[LAST-1:0]), $past(ser_in)}); // R4

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !shift_pulse) |=> $stable(shift_q)); // R4

    AST_COINCIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && shift_pulse && cap_pulse) |=>
            (shift_q[LAST:1] == $past(shift_q[LAST-1:0]) &&
             store_q == $past(par_in))); // R5

    AST_SINGLE_SHIFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse); // R8

    AST_SINGLE_CAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> !cap_pulse); // R8

endmodule

bind piso_latched_shifter piso_latched_shifter_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .par_in      (par_in),
    .load_n      (load_n),
    .ser_in      (ser_in),
    .cap_pulse   (cap_pulse),
    .shift_pulse (shift_pulse),
    .store_q     (store_q),
    .shift_q     (shift_q)
);

// File: tb/piso_latched_shifter_tb_top.sv
// Self-checking bench: fills and drains all 256 words, then covers the
// override, coincidence, pass-through, held-strobe and output-enable cases.
module piso_latched_shifter_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         cap_strobe = 1'b0;
    logic         shift_strobe = 1'b0;
    logic         load_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         oe_n = 1'b0;
    logic         ser_out;
    logic         ser_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [W-1:0] exp_store = '0;
    logic [W-1:0] exp_shift = '0;

    always #2.5 clk = ~clk;

    piso_latched_shifter #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .par_in       (par_in),
        .cap_strobe   (cap_strobe),
        .shift_strobe (shift_strobe),
        .load_n       (load_n),
        .ser_in       (ser_in),
        .oe_n         (oe_n),
        .ser_out      (ser_out),
        .ser_oe       (ser_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check_bit({req, " drive"}, ser_oe, 1'b1);
        check_bit(req, ser_out, exp_shift[W-1]);
    endtask

    task automatic pulse_cap(input logic [W-1:0] v);
        par_in = v;
        cap_strobe = 1'b1;
        tick(4);
        cap_strobe = 1'b0;
        tick(3);
        exp_store = v;
        if (!load_n) exp_shift = v;
    endtask

    task automatic pulse_shift(input logic s);
        ser_in = s;
        shift_strobe = 1'b1;
        tick(4);
        shift_strobe = 1'b0;
        tick(3);
        if (load_n) exp_shift = {exp_shift[W-2:0], s};
    endtask

    task automatic fill();
        load_n = 1'b0;
        tick(2);
        exp_shift = exp_store;
        load_n = 1'b1;
        tick(1);
    endtask

    task automatic drain(input string req, input logic [W-1:0] pat);
        for (int i = 0; i < W; i++) begin
            pulse_shift(pat[i]);
            check_out(req);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: output of the cleared shift register, then the cleared holding register.
        check_out("R1 reset shifter");
        drain("R1 shifter zero", 8'h00);
        fill();
        check_out("R1 store zero");

        // R2 R3 R4: sweep every parallel word through capture, fill and drain.
        for (int v = 0; v < 256; v++) begin
            pulse_cap(v[W-1:0]);
            fill();
            check_out("R2 R3 fill top bit");
            drain("R4 shift", ~v[W-1:0]);
        end

        // R3: a shift edge while load_n is low has no effect.
        pulse_cap(8'hA5);
        fill();
        load_n = 1'b0;
        tick(1);
        pulse_shift(1'b0);
        exp_shift = exp_store;
        check_out("R3 override");
        load_n = 1'b1;
        tick(1);
        drain("R3 after override", 8'h00);

        // R8: a strobe held high shifts only once.
        pulse_cap(8'hC3);
        fill();
        ser_in = 1'b1;
        shift_strobe = 1'b1;
        tick(20);
        shift_strobe = 1'b0;
        tick(3);
        exp_shift = {exp_shift[W-2:0], 1'b1};
        check_out("R8 single shift");
        drain("R8 remaining", 8'h00);

        // R5: both strobes together. The old contents shift and the store takes the new word.
        pulse_cap(8'h96);
        fill();
        par_in = 8'h3C;
        ser_in = 1'b1;
        cap_strobe = 1'b1;
        shift_strobe = 1'b1;
        tick(4);
        cap_strobe = 1'b0;
        shift_strobe = 1'b0;
        tick(3);
        exp_shift = {exp_shift[W-2:0], 1'b1};
        exp_store = 8'h3C;
        check_out("R5 coincident shift");
        drain("R5 old word", 8'h55);
        // R9: the store kept the new word through the shifts.
        fill();
        check_out("R9 store held");
        drain("R9 store word", 8'h00);

        // R6: capture while load_n is low, sampled in the one cycle where pins and store differ.
        pulse_cap(8'h00);
        load_n = 1'b0;
        tick(2);
        par_in = 8'hFF;
        cap_strobe = 1'b1;
        tick(2);
        // After this edge the pulse has acted; pass-through puts bit W-1 = 1 on the output.
        @(posedge clk);
        @(negedge clk);
        exp_shift = 8'hFF;
        check_out("R6 pass-through same cycle");
        cap_strobe = 1'b0;
        exp_store = 8'hFF;
        tick(3);
        load_n = 1'b1;
        tick(1);
        drain("R6 word", 8'h00);

        // R10: the capture acts on the third edge and not before.
        pulse_cap(8'h00);
        load_n = 1'b0;
        tick(2);
        par_in = 8'h80;
        cap_strobe = 1'b1;
        tick(1);
        @(posedge clk);
        @(negedge clk);
        check_bit("R10 not yet", ser_out, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check_bit("R10 third edge", ser_out, 1'b1);
        cap_strobe = 1'b0;
        exp_store = 8'h80;
        exp_shift = 8'h80;
        tick(3);
        load_n = 1'b1;
        tick(1);

        // R7: disabled output, shifting continues behind it.
        pulse_cap(8'h5A);
        fill();
        oe_n = 1'b1;
        tick(1);
        check_bit("R7 drive off", ser_oe, 1'b0);
        pulse_shift(1'b0);
        pulse_shift(1'b1);
        check_bit("R7 drive stays off", ser_oe, 1'b0);
        oe_n = 1'b0;
        tick(1);
        check_out("R7 re-enabled");
        drain("R7 remaining", 8'h0F);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule